// File: doc/BRIEF.md
# Contact Image Sensor Scan Controller

This block produces the digital drive for a row of cascaded contact-image-sensor chips, running from a fast system clock. It makes the sensor shift clock, the start pulse that launches a scan token into the first chip, a one-cycle video-line reset strobe at the start of every pixel clock and a one-cycle ADC sample strobe in the low phase. Alongside these it reports which pixel is being read (`pix_idx`, qualified by `line_valid`), and it watches the end-of-scan return from the last chip of the row. When that return is missing, early or late, it raises `eos_err`.

Each chip holds 64 pixels and the chip count is a parameter, so a line is 64 × `CHIPS` pixels. Time inside a line is counted in pixel slots. The token is captured in slot 0, and pixel k is read in slot k+1. All settings are plain inputs: pixel clock period, high time, sample delay and line period. The timing settings are taken at the start of each pixel slot and the line period at the start of each line. Values that would break the sensor's timing are clamped. No output has a valid/ready handshake, because the sensor cannot be stalled. The pixel index and `line_valid` are a timing reference for the downstream sampler, not a flow-controlled stream.

Top module: `cis_scan_ctrl`

## Requirements
- R1: The shift clock period is max(`cfg_period`, 4) system clocks. Each period starts with a rising edge.
- R2: The shift clock stays high for `cfg_high` system clocks, clamped to the range 2 … period/2. This gives at least 2 cycles of both high and low time.
- R3: `rst_stb` is high for exactly one system clock per pixel slot, in the cycle where the shift clock rises, and at no other time.
- R4: `smp_stb` is high for exactly one system clock per pixel slot. It comes `cfg_dly` system clocks after the shift clock's falling edge, with the delay clamped to period − 1 − high time, so it always lands in the low phase.
- R5: `sp` rises together with the shift clock at the start of slot 0 and stays high for exactly one pixel period. It therefore spans exactly one falling edge of the shift clock, with high-time cycles of setup and low-time cycles of hold.
- R6: The line period, measured between `sp` rises, is max(`cfg_line`, 64 × `CHIPS` + 1) pixel periods. `cfg_line` is taken only at a line start. A change in mid-line affects the next line only, and `sp` never rises while `line_valid` is high.
- R7: `line_valid` is high in slots 1 to 64 × `CHIPS`, changing with the shift clock's rising edge. During those slots `pix_idx` equals slot − 1, counting 0, 1, … 64 × `CHIPS` − 1.
- R8: If `eos_in` is seen high during the last pixel slot (slot 64 × `CHIPS`), `eos_err` is 0 from the start of the next slot. If `eos_in` does not appear in the readout slots, `eos_err` becomes 1. `eos_err` holds its value until the next line's check and is reset only by `rst_n`.
- R9: If `eos_in` arrives in an earlier readout slot s, `line_valid` falls at the next slot start, so only s pixels are flagged, and `eos_err` becomes 1. `eos_in` outside the readout slots is ignored.
- R10: While `en` is low, all strobe and timing outputs are 0 from the next clock. The cycle after `en` is seen high, `sclk`, `sp` and `rst_stb` are all 1.
- R11: During and after reset with `en` low, `sclk`, `sp`, `rst_stb`, `smp_stb`, `line_valid` and `eos_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low stops scanning and idles outputs |
| cfg_period | input | PER_W | Pixel clock period in system clocks |
| cfg_high | input | PER_W | Shift clock high time in system clocks |
| cfg_dly | input | PER_W | Sample strobe delay after the falling edge |
| cfg_line | input | LINE_W | Line period in pixel clocks (integration time) |
| eos_in | input | 1 | End-of-scan return from the last chip |
| sclk | output | 1 | Sensor shift clock |
| sp | output | 1 | Sensor start pulse |
| rst_stb | output | 1 | Video-line reset (shunt) strobe |
| smp_stb | output | 1 | ADC sample strobe |
| pix_idx | output | $clog2(64×CHIPS) | Index of the pixel being read |
| line_valid | output | 1 | High during readout slots |
| eos_err | output | 1 | End-of-scan return missing or misplaced |

## Verification
The hardest case to reach from the ports is the end-of-scan check on a line trimmed to its minimum length. In that case the last pixel slot is also the final slot of the line, so the error verdict, the reset of the pixel count and the next start pulse all land on the same edge. The bench models the sensor's return. It counts shift-clock rises since each start pulse and drives `eos_in` in the low phase of a chosen slot: the last pixel slot, an earlier slot, a slot after readout, or not at all. It then reads `eos_err` and the number of flagged pixels at the following start pulse, with lines clamped up from a too-short setting as well as longer ones.

// File: rtl/cis_pkg.sv
package cis_pkg;
  // pixels held by one sensor chip
  localparam int PIX_PER_CHIP = 64;
  // smallest pixel clock period in system clocks (2 high + 2 low)
  localparam int MIN_PERIOD = 4;
  // smallest shift clock high time, also the start pulse setup margin
  localparam int MIN_HIGH = 2;
endpackage

// File: rtl/cis_pix_timer.sv
module cis_pix_timer
  import cis_pkg::*;
#(
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [PER_W-1:0] cfg_high,
  input  logic [PER_W-1:0] cfg_dly,
  output logic             slot_start,
  output logic             sclk,
  output logic             rst_stb,
  output logic             smp_stb
);
  localparam logic [PER_W-1:0] P_MIN = PER_W'(MIN_PERIOD);
  localparam logic [PER_W-1:0] H_MIN = PER_W'(MIN_HIGH);
  localparam logic [PER_W-1:0] ONE   = PER_W'(1);

  logic [PER_W-1:0] ph, ph_inc;
  logic [PER_W-1:0] p_q, h_q, d_q;
  logic [PER_W-1:0] p_c, h_c, d_c, half, room;
  logic             run;

  // clamp the settings to the sensor's legal timing
  always_comb begin
    p_c  = (cfg_period < P_MIN) ? P_MIN : cfg_period;
    half = p_c >> 1;
    if (cfg_high < H_MIN)     h_c = H_MIN;
    else if (cfg_high > half) h_c = half;
    else                      h_c = cfg_high;
    room = p_c - ONE - h_c;
    d_c  = (cfg_dly > room) ? room : cfg_dly;
  end

  assign ph_inc     = ph + ONE;
  assign slot_start = en && (!run || (ph == p_q - ONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= '0;
      run     <= 1'b0;
      p_q     <= P_MIN;
      h_q     <= H_MIN;
      d_q     <= '0;
      sclk    <= 1'b0;
      rst_stb <= 1'b0;
      smp_stb <= 1'b0;
    end else if (!en) begin
      ph      <= '0;
      run     <= 1'b0;
      sclk    <= 1'b0;
      rst_stb <= 1'b0;
      smp_stb <= 1'b0;
    end else if (slot_start) begin
      ph      <= '0;
      run     <= 1'b1;
      p_q     <= p_c;
      h_q     <= h_c;
      d_q     <= d_c;
      sclk    <= 1'b1;
      rst_stb <= 1'b1;
      smp_stb <= 1'b0;
    end else begin
      ph      <= ph_inc;
      sclk    <= (ph_inc < h_q);
      rst_stb <= 1'b0;
      smp_stb <= (ph_inc == h_q + d_q);
    end
  end

  // R2: a falling edge not caused by disable follows at least two high cycles
  p_high_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk) && $past(en)) |-> $past(sclk, 2));

  // R3: reset strobe only on the rising edge of the shift clock
  p_rst_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_stb |-> (sclk && !$past(sclk)));

  // R4: sample strobe only in the low phase
  p_smp_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> !sclk);

  // R4: sample strobe is a single-cycle pulse
  p_smp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> !smp_stb);
endmodule

// File: rtl/cis_line_seq.sv
module cis_line_seq
  import cis_pkg::*;
#(
  parameter int NPIX   = 832,
  parameter int LINE_W = 16,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              slot_start,
  input  logic              sclk,
  input  logic              eos_in,
  input  logic [LINE_W-1:0] cfg_line,
  output logic              sp,
  output logic              line_valid,
  output logic [IDX_W-1:0]  pix_idx,
  output logic              eos_err
);
  localparam logic [LINE_W-1:0] LAST_PIX = LINE_W'(NPIX);
  localparam logic [LINE_W-1:0] MIN_LINE = LINE_W'(NPIX + 1);
  localparam logic [LINE_W-1:0] ONE      = LINE_W'(1);

  logic [LINE_W-1:0] slot, slot_inc, l_q, l_c;
  logic              started, ended, ended_nx, eos_seen, eos_hit;

  assign l_c      = (cfg_line < MIN_LINE) ? MIN_LINE : cfg_line;
  assign slot_inc = slot + ONE;
  assign eos_hit  = eos_seen || eos_in;
  // readout stops after the return arrives or after the last pixel slot
  assign ended_nx = ended || (line_valid && (eos_hit || slot == LAST_PIX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot       <= '0;
      l_q        <= MIN_LINE;
      started    <= 1'b0;
      ended      <= 1'b0;
      eos_seen   <= 1'b0;
      sp         <= 1'b0;
      line_valid <= 1'b0;
      pix_idx    <= '0;
      eos_err    <= 1'b0;
    end else if (!en) begin
      slot       <= '0;
      started    <= 1'b0;
      ended      <= 1'b0;
      eos_seen   <= 1'b0;
      sp         <= 1'b0;
      line_valid <= 1'b0;
      pix_idx    <= '0;
    end else begin
      if (line_valid && eos_in) eos_seen <= 1'b1;
      if (slot_start) begin
        eos_seen <= 1'b0;
        // verdict on the slot that is closing
        if (line_valid) begin
          if (eos_hit)               eos_err <= (slot != LAST_PIX);
          else if (slot == LAST_PIX) eos_err <= 1'b1;
        end
        if (!started || slot == l_q - ONE) begin
          slot       <= '0;
          l_q        <= l_c;
          started    <= 1'b1;
          ended      <= 1'b0;
          sp         <= 1'b1;
          line_valid <= 1'b0;
          pix_idx    <= '0;
        end else begin
          slot       <= slot_inc;
          ended      <= ended_nx;
          sp         <= 1'b0;
          line_valid <= !ended_nx && (slot_inc <= LAST_PIX);
          pix_idx    <= IDX_W'(slot);
        end
      end
    end
  end

  // R5: the start pulse begins on a shift clock rise
  p_sp_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sp) |-> $rose(sclk));

  // R5: the start pulse never spans a second rise, so one falling edge only
  p_sp_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sp && $past(sp)) |-> !$rose(sclk));

  // R6: no new start pulse during readout
  p_no_sp_midline_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sp |-> !line_valid);

  // R7: index in range while valid
  p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> (int'(pix_idx) < NPIX));

  // R7: index advances by one between valid slots
  p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && $past(line_valid) && (pix_idx != $past(pix_idx)))
      |-> (pix_idx == $past(pix_idx) + IDX_W'(1)));
endmodule

// File: rtl/cis_scan_ctrl.sv
module cis_scan_ctrl
  import cis_pkg::*;
#(
  parameter int CHIPS  = 13,
  parameter int PER_W  = 10,
  parameter int LINE_W = 16,
  localparam int NPIX  = PIX_PER_CHIP * CHIPS,
  localparam int IDX_W = $clog2(NPIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PER_W-1:0]  cfg_period,
  input  logic [PER_W-1:0]  cfg_high,
  input  logic [PER_W-1:0]  cfg_dly,
  input  logic [LINE_W-1:0] cfg_line,
  input  logic              eos_in,
  output logic              sclk,
  output logic              sp,
  output logic              rst_stb,
  output logic              smp_stb,
  output logic [IDX_W-1:0]  pix_idx,
  output logic              line_valid,
  output logic              eos_err
);
  logic slot_start;

  cis_pix_timer #(.PER_W(PER_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .cfg_period (cfg_period),
    .cfg_high   (cfg_high),
    .cfg_dly    (cfg_dly),
    .slot_start (slot_start),
    .sclk       (sclk),
    .rst_stb    (rst_stb),
    .smp_stb    (smp_stb)
  );

  cis_line_seq #(.NPIX(NPIX), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .slot_start (slot_start),
    .sclk       (sclk),
    .eos_in     (eos_in),
    .cfg_line   (cfg_line),
    .sp         (sp),
    .line_valid (line_valid),
    .pix_idx    (pix_idx),
    .eos_err    (eos_err)
  );

  // R10: a low enable idles every timing output on the next cycle
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !(sclk || sp || rst_stb || smp_stb || line_valid));
endmodule

// File: tb/test_cis_scan_ctrl.sv
module test_cis_scan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CHIPS  = 1;
  localparam int NPIX   = 64 * CHIPS;
  localparam int PER_W  = 10;
  localparam int LINE_W = 16;
  localparam int IDX_W  = $clog2(NPIX);
  localparam int NVEC   = 7;
  // cfg P,H,D,L,eos slot (0 = none) | expected P,H,D,L slots,valid pixels,err
  localparam int VEC [NVEC][11] = '{
    '{ 8, 2, 1, 70, 64,   8, 2, 1, 70, 64, 0},
    '{10, 5, 3, 65, 64,  10, 5, 3, 65, 64, 0},
    '{ 4, 1, 5, 10, 64,   4, 2, 1, 65, 64, 0},
    '{ 2, 9, 0, 80,  0,   4, 2, 0, 80, 64, 1},
    '{12, 6, 2, 66, 40,  12, 6, 2, 66, 40, 1},
    '{ 6, 3, 2, 66, 65,   6, 3, 2, 66, 64, 1},
    '{ 8, 2, 1, 70, 64,   8, 2, 1, 70, 64, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic eos_in = 1'b0;
  logic [PER_W-1:0]  cfg_period = '0;
  logic [PER_W-1:0]  cfg_high = '0;
  logic [PER_W-1:0]  cfg_dly = '0;
  logic [LINE_W-1:0] cfg_line = '0;
  logic sclk, sp, rst_stb, smp_stb, line_valid, eos_err;
  logic [IDX_W-1:0] pix_idx;

  cis_scan_ctrl #(.CHIPS(CHIPS), .PER_W(PER_W), .LINE_W(LINE_W)) i_cis_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_period(cfg_period), .cfg_high(cfg_high), .cfg_dly(cfg_dly),
    .cfg_line(cfg_line), .eos_in(eos_in),
    .sclk(sclk), .sp(sp), .rst_stb(rst_stb), .smp_stb(smp_stb),
    .pix_idx(pix_idx), .line_valid(line_valid), .eos_err(eos_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int eos_at = 0;
  int lines = 0;
  // live counters of the line in progress
  int since_sp = 0, since_rise = 0, since_fall = 0;
  int cur_slots = 0, cur_valid = 0, cur_spf = 0, cur_rst = 0, cur_rstbad = 0;
  int cur_smp = 0, cur_idxbad = 0;
  // snapshots of the last complete line
  int m_cyc = 0, m_per = 0, m_hi = 0, m_sd = 0, m_slots = 0, m_valid = 0;
  int m_spf = 0, m_rst = 0, m_rstbad = 0, m_smp = 0, m_idxbad = 0, m_err = 0;
  logic sclk_d = 1'b0, sp_d = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor and sensor return model, sampling away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      begin
        bit rise, fall;
        rise = sclk && !sclk_d;
        fall = !sclk && sclk_d;
        if (sp && !sp_d) begin
          m_cyc = since_sp; since_sp = 0;
          m_slots = cur_slots; m_valid = cur_valid; m_spf = cur_spf;
          m_rst = cur_rst; m_rstbad = cur_rstbad; m_smp = cur_smp;
          m_idxbad = cur_idxbad; m_err = int'(eos_err);
          cur_slots = 0; cur_valid = 0; cur_spf = 0; cur_rst = 0;
          cur_rstbad = 0; cur_smp = 0; cur_idxbad = 0;
          lines++;
        end
        if (rise) begin
          m_per = since_rise; since_rise = 0; cur_slots++;
          if (line_valid) begin
            if (int'(pix_idx) != cur_valid) cur_idxbad++;
            cur_valid++;
          end
        end
        if (fall) begin
          m_hi = since_rise; since_fall = 0;
          if (sp) cur_spf++;
        end
        if (rst_stb) begin
          cur_rst++;
          if (!rise) cur_rstbad++;
        end
        if (smp_stb) begin
          cur_smp++; m_sd = since_fall;
        end
        since_sp++; since_rise++; since_fall++;
        sclk_d = sclk; sp_d = sp;
        eos_in = (eos_at > 0) && (cur_slots - 1 == eos_at) && !sclk;
      end
    end
  end

  task automatic run_vec(input int v);
    int base;
    @(negedge clk);
    cfg_period = PER_W'(VEC[v][0]);
    cfg_high   = PER_W'(VEC[v][1]);
    cfg_dly    = PER_W'(VEC[v][2]);
    cfg_line   = LINE_W'(VEC[v][3]);
    eos_at     = VEC[v][4];
    base = lines;
    en = 1'b1;
    while (lines < base + 3) @(negedge clk);
    chk("R1 period", m_per, VEC[v][5]);
    chk("R2 high time", m_hi, VEC[v][6]);
    chk("R4 sample delay", m_sd, VEC[v][7]);
    chk("R4 samples per line", m_smp, VEC[v][8]);
    chk("R3 resets per line", m_rst, VEC[v][8]);
    chk("R3 reset off rise", m_rstbad, 0);
    chk("R5 falls under sp", m_spf, 1);
    chk("R6 line slots", m_slots, VEC[v][8]);
    chk("R6 line cycles", m_cyc, VEC[v][8] * VEC[v][5]);
    chk("R7 R9 valid pixels", m_valid, VEC[v][9]);
    chk("R7 index order", m_idxbad, 0);
    chk("R8 R9 eos_err", m_err, VEC[v][10]);
    en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL R10 watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 outputs in reset", int'({sclk, sp, rst_stb, smp_stb, line_valid, eos_err}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 idle after reset", int'({sclk, sp, rst_stb, smp_stb, line_valid, eos_err}), 0);

    // R10: start on enable, idle on disable
    cfg_period = 8; cfg_high = 2; cfg_dly = 1; cfg_line = 70; eos_at = 64;
    en = 1'b1;
    @(negedge clk);
    chk("R10 R5 first cycle sclk sp rst", int'({sclk, sp, rst_stb}), 7);
    repeat (30) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R10 idle after disable", int'({sclk, sp, rst_stb, smp_stb, line_valid}), 0);
    repeat (3) @(negedge clk);

    // table of vectors
    for (int v = 0; v < NVEC; v++) run_vec(v);

    // R6: line period latched at line start
    begin
      int base;
      @(negedge clk);
      cfg_period = 8; cfg_high = 2; cfg_dly = 1; cfg_line = 70; eos_at = 64;
      base = lines;
      en = 1'b1;
      while (lines < base + 2) @(negedge clk);
      repeat (20) @(negedge clk);
      cfg_line = 100;
      while (lines < base + 3) @(negedge clk);
      chk("R6 mid-line change deferred", m_cyc, 70 * 8);
      while (lines < base + 4) @(negedge clk);
      chk("R6 new line period", m_cyc, 100 * 8);
      chk("R8 eos_err clear", m_err, 0);
      en = 1'b0;
      repeat (3) @(negedge clk);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule